// File: doc/BRIEF.md
# AC-link codec register access engine

This block turns host requests for codec register writes and reads into the command words of an AC'97 serial link. It also collects the status words the codec sends back. The host first loads the data word, then writes the command word, which holds the register address and a read flag. The command write arms a transfer, and the next frame that the engine is allowed to use carries the command, together with the data if the data is pending. A busy flag for each slot stays high until that slot has left in a frame.

Frames reach the block as a one-cycle frame-start strobe and parallel slot ports. On a strobe the block latches the words it will send during the coming frame. In the same cycle the inbound ports carry the command and status words of the frame just received. The block captures them into two receive registers, each with a valid flag. After a read command has gone out, a tracker waits for the codec's answer. It checks the echoed register index and reports the data, a mismatch error or a timeout. After reset the block holds the codec reset low for a set number of cycles and then waits a wake-up time. Only after that does it use any frame.

Top module: `ac_link_cmd_engine`

## Requirements
- R1: An outgoing command word has the read flag in bit 19, the 7-bit register index in bits 18:12 and zeros in bits 11:0.
- R2: An outgoing data word has the 16-bit write data in bits 19:4 and zeros in bits 3:0.
- R3: Loading the data word alone sends nothing. A command write arms the transfer, and the data word goes out only in the same frame as a command word.
- R4: Each busy flag is set in the cycle after the host write to its slot. It clears in the cycle after the frame-start strobe of the frame that sends the slot.
- R5: The command slot is held pending while the command transmit enable is low. If the data transmit enable is low when the command goes out, the data word stays pending for a later command.
- R6: From the cycle after a frame start until the next one, a tag output is high only if its slot carries fresh content in that frame. A slot with no fresh content drives zero.
- R7: On a frame start after link ready, a received slot whose inbound tag and receive enable are both high is captured, and its valid flag is set. An acknowledge pulse clears the flag. A capture wins over an acknowledge in the same cycle. With the receive enable low, the word and the flag keep their values.
- R8: After a read command is sent, rd_busy stays high. The first later frame that brings both inbound tags, with both receive enables set, ends the read. If the echoed index in bits 18:12 matches the request, rd_data is bits 19:4 of the status word, and rd_err and rd_timeout are low.
- R9: On an echoed index mismatch, rd_data is 16'hFFFF and rd_err is high.
- R10: If none of TIMEOUT_FRAMES (4) frames after the send brings valid status, the read ends with rd_data 16'hFFFF and rd_timeout high.
- R11: codec_rst_n is low for RESET_CYCLES cycles after reset, and link_ready rises WAKE_CYCLES cycles later. No slot is sent or captured while link_ready is low.
- R12: rd_done is a single-cycle pulse in the cycle after the frame start that ends a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data_we | input | 1 | Load the data slot word |
| host_data | input | 16 | Register write data |
| host_cmd_we | input | 1 | Load the command slot word and arm the transfer |
| host_cmd_read | input | 1 | Command is a read |
| host_cmd_addr | input | 7 | Codec register index |
| host_rx1_ack | input | 1 | Host has read the received command word |
| host_rx2_ack | input | 1 | Host has read the received status data word |
| en_tx_cmd | input | 1 | Command slot transmit enable |
| en_tx_data | input | 1 | Data slot transmit enable |
| en_rx_cmd | input | 1 | Command slot receive enable |
| en_rx_data | input | 1 | Data slot receive enable |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| rx_cmd_slot | input | 20 | Received command-echo slot word |
| rx_data_slot | input | 20 | Received status data slot word |
| rx_cmd_tag | input | 1 | Inbound tag: command-echo slot valid |
| rx_data_tag | input | 1 | Inbound tag: status data slot valid |
| tx_cmd_slot | output | 20 | Outgoing command slot word |
| tx_data_slot | output | 20 | Outgoing data slot word |
| tx_cmd_tag | output | 1 | Outgoing tag: command slot fresh |
| tx_data_tag | output | 1 | Outgoing tag: data slot fresh |
| cmd_busy | output | 1 | Command slot pending |
| data_busy | output | 1 | Data slot pending |
| rx_cmd_word | output | 20 | Captured command-echo word |
| rx_data_word | output | 20 | Captured status data word |
| rx_cmd_valid | output | 1 | Captured command-echo word not yet acknowledged |
| rx_data_valid | output | 1 | Captured data word not yet acknowledged |
| rd_busy | output | 1 | Read waiting for status |
| rd_done | output | 1 | Read finished pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Last read saw an index mismatch |
| rd_timeout | output | 1 | Last read timed out |
| codec_rst_n | output | 1 | Active-low codec reset |
| link_ready | output | 1 | Reset and wake-up sequence complete |

## Verification
The hardest situation to reach is a data word left pending while the command that should carry it leaves without it. The bench lowers the data transmit enable and then issues a command, so the command frame goes out without the data. A later command with the enable raised must then carry the stale data word. Commands issued with the command enable low, and again before link_ready, hold the busy flags across several frames. The read tracker is driven through a matching echo, a wrong echo and four silent frames, with a check after the third silent frame that the read is still open.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;

    localparam int SLOT_W = 20;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              err;
        logic              timeout;
    } rd_result_t;

    typedef enum logic {
        TRK_IDLE,
        TRK_WAIT
    } trk_state_t;

    function automatic slot_t pack_cmd(input cmd_t c);
        return {c.rd, c.addr, {(SLOT_W-ADDR_W-1){1'b0}}};
    endfunction

    function automatic slot_t pack_data(input logic [DATA_W-1:0] d);
        return {d, {(SLOT_W-DATA_W){1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] echo_addr(input slot_t s);
        return s[SLOT_W-2 -: ADDR_W];
    endfunction

    function automatic logic [DATA_W-1:0] status_data(input slot_t s);
        return s[SLOT_W-1 -: DATA_W];
    endfunction

endpackage

// File: rtl/ac_reset_seq.sv
module ac_reset_seq #(
    parameter int RESET_CYCLES = 100,
    parameter int WAKE_CYCLES  = 2100
) (
    input  logic clk,
    input  logic rst,
    output logic codec_rst_n,
    output logic link_ready
);
    localparam int TOTAL = RESET_CYCLES + WAKE_CYCLES;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != CW'(TOTAL)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign codec_rst_n = (cnt >= CW'(RESET_CYCLES));
    assign link_ready  = (cnt == CW'(TOTAL));
endmodule

// File: rtl/ac_tx_stage.sv
module ac_tx_stage
    import ac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              link_ready,
    input  logic              en_cmd,
    input  logic              en_data,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wr_cmd,
    input  cmd_t              cmd_in,
    output slot_t             tx_cmd,
    output slot_t             tx_data,
    output logic              tag_cmd,
    output logic              tag_data,
    output logic              busy_cmd,
    output logic              busy_data,
    output logic              sent_read,
    output logic [ADDR_W-1:0] sent_addr
);
    slot_t pend_cmd, pend_data;
    logic  send_cmd, send_data;

    assign send_cmd  = frame_start && link_ready && busy_cmd && en_cmd;
    assign send_data = send_cmd && busy_data && en_data;
    assign sent_read = send_cmd && pend_cmd[SLOT_W-1];
    assign sent_addr = echo_addr(pend_cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cmd  <= '0;
            pend_data <= '0;
            busy_cmd  <= 1'b0;
            busy_data <= 1'b0;
            tx_cmd    <= '0;
            tx_data   <= '0;
            tag_cmd   <= 1'b0;
            tag_data  <= 1'b0;
        end else begin
            if (frame_start) begin
                tx_cmd   <= send_cmd  ? pend_cmd  : '0;
                tx_data  <= send_data ? pend_data : '0;
                tag_cmd  <= send_cmd;
                tag_data <= send_data;
            end
            if (wr_cmd) begin
                pend_cmd <= pack_cmd(cmd_in);
                busy_cmd <= 1'b1;
            end else if (send_cmd) begin
                busy_cmd <= 1'b0;
            end
            if (wr_data) begin
                pend_data <= pack_data(data_in);
                busy_data <= 1'b1;
            end else if (send_data) begin
                busy_data <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ac_rx_capture.sv
module ac_rx_capture
    import ac_cmd_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_start,
    input  logic                         link_ready,
    input  logic [LANES-1:0][SLOT_W-1:0] rx_in,
    input  logic [LANES-1:0]             rx_tag,
    input  logic [LANES-1:0]             rx_en,
    input  logic [LANES-1:0]             ack,
    output logic [LANES-1:0][SLOT_W-1:0] word,
    output logic [LANES-1:0]             valid
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        slot_t q;
        logic  v;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                v <= 1'b0;
            end else if (frame_start && link_ready && rx_tag[i] && rx_en[i]) begin
                q <= rx_in[i];
                v <= 1'b1;
            end else if (ack[i]) begin
                v <= 1'b0;
            end
        end
        assign word[i]  = q;
        assign valid[i] = v;
    end
endmodule

// File: rtl/ac_read_tracker.sv
module ac_read_tracker
    import ac_cmd_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              link_ready,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              status_ok,
    input  slot_t             echo_slot,
    input  slot_t             data_slot,
    output logic              busy,
    output logic              done,
    output rd_result_t        result
);
    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);

    trk_state_t        state;
    logic [CNT_W-1:0]  frames;
    logic [ADDR_W-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TRK_IDLE;
            frames <= '0;
            want   <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state  <= TRK_WAIT;
                frames <= '0;
                want   <= start_addr;
            end else if (state == TRK_WAIT && frame_start && link_ready) begin
                if (status_ok) begin
                    state <= TRK_IDLE;
                    done  <= 1'b1;
                    if (echo_addr(echo_slot) == want) begin
                        result <= '{data: status_data(data_slot), err: 1'b0, timeout: 1'b0};
                    end else begin
                        result <= '{data: '1, err: 1'b1, timeout: 1'b0};
                    end
                end else if (frames == CNT_W'(TIMEOUT_FRAMES - 1)) begin
                    state  <= TRK_IDLE;
                    done   <= 1'b1;
                    result <= '{data: '1, err: 1'b0, timeout: 1'b1};
                end else begin
                    frames <= frames + 1'b1;
                end
            end
        end
    end

    assign busy = (state == TRK_WAIT);
endmodule

// File: rtl/ac_link_cmd_engine.sv
module ac_link_cmd_engine
    import ac_cmd_pkg::*;
#(
    parameter int RESET_CYCLES   = 100,
    parameter int WAKE_CYCLES    = 2100,
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_data_we,
    input  logic [15:0] host_data,
    input  logic        host_cmd_we,
    input  logic        host_cmd_read,
    input  logic [6:0]  host_cmd_addr,
    input  logic        host_rx1_ack,
    input  logic        host_rx2_ack,
    input  logic        en_tx_cmd,
    input  logic        en_tx_data,
    input  logic        en_rx_cmd,
    input  logic        en_rx_data,
    input  logic        frame_start,
    input  logic [19:0] rx_cmd_slot,
    input  logic [19:0] rx_data_slot,
    input  logic        rx_cmd_tag,
    input  logic        rx_data_tag,
    output logic [19:0] tx_cmd_slot,
    output logic [19:0] tx_data_slot,
    output logic        tx_cmd_tag,
    output logic        tx_data_tag,
    output logic        cmd_busy,
    output logic        data_busy,
    output logic [19:0] rx_cmd_word,
    output logic [19:0] rx_data_word,
    output logic        rx_cmd_valid,
    output logic        rx_data_valid,
    output logic        rd_busy,
    output logic        rd_done,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        rd_timeout,
    output logic        codec_rst_n,
    output logic        link_ready
);
    logic              sent_read;
    logic [ADDR_W-1:0] sent_addr;
    logic [1:0][SLOT_W-1:0] cap_word;
    logic [1:0]        cap_valid;
    rd_result_t        res;
    cmd_t              cmd;

    assign cmd = '{rd: host_cmd_read, addr: host_cmd_addr};

    ac_reset_seq #(.RESET_CYCLES(RESET_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_rst (
        .clk(clk), .rst(rst), .codec_rst_n(codec_rst_n), .link_ready(link_ready)
    );

    ac_tx_stage u_tx (
        .clk(clk), .rst(rst), .frame_start(frame_start), .link_ready(link_ready),
        .en_cmd(en_tx_cmd), .en_data(en_tx_data),
        .wr_data(host_data_we), .data_in(host_data),
        .wr_cmd(host_cmd_we), .cmd_in(cmd),
        .tx_cmd(tx_cmd_slot), .tx_data(tx_data_slot),
        .tag_cmd(tx_cmd_tag), .tag_data(tx_data_tag),
        .busy_cmd(cmd_busy), .busy_data(data_busy),
        .sent_read(sent_read), .sent_addr(sent_addr)
    );

    ac_rx_capture #(.LANES(2)) u_rx (
        .clk(clk), .rst(rst), .frame_start(frame_start), .link_ready(link_ready),
        .rx_in({rx_data_slot, rx_cmd_slot}),
        .rx_tag({rx_data_tag, rx_cmd_tag}),
        .rx_en({en_rx_data, en_rx_cmd}),
        .ack({host_rx2_ack, host_rx1_ack}),
        .word(cap_word), .valid(cap_valid)
    );

    assign rx_cmd_word   = cap_word[0];
    assign rx_data_word  = cap_word[1];
    assign rx_cmd_valid  = cap_valid[0];
    assign rx_data_valid = cap_valid[1];

    ac_read_tracker #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_trk (
        .clk(clk), .rst(rst), .frame_start(frame_start), .link_ready(link_ready),
        .start(sent_read), .start_addr(sent_addr),
        .status_ok(rx_cmd_tag && rx_data_tag && en_rx_cmd && en_rx_data),
        .echo_slot(rx_cmd_slot), .data_slot(rx_data_slot),
        .busy(rd_busy), .done(rd_done), .result(res)
    );

    assign rd_data    = res.data;
    assign rd_err     = res.err;
    assign rd_timeout = res.timeout;
endmodule

// File: rtl/ac_link_cmd_checker.sv
module ac_link_cmd_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_cmd_we,
    input logic        en_tx_cmd,
    input logic        frame_start,
    input logic        tx_cmd_tag,
    input logic        tx_data_tag,
    input logic        cmd_busy,
    input logic        rx_cmd_valid,
    input logic        rd_busy,
    input logic        rd_done,
    input logic [15:0] rd_data,
    input logic        rd_err,
    input logic        rd_timeout,
    input logic        link_ready
);
    assert_cmd_leaves_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start && link_ready && cmd_busy && en_tx_cmd && !host_cmd_we |=> !cmd_busy && tx_cmd_tag);

    assert_data_with_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        tx_data_tag |-> tx_cmd_tag);

    assert_cmd_gated_R5: assert property (@(posedge clk) disable iff (rst)
        frame_start && !en_tx_cmd |=> !tx_cmd_tag);

    assert_quiet_before_ready_R11: assert property (@(posedge clk) disable iff (rst)
        !link_ready |=> !tx_cmd_tag);

    assert_capture_on_frame_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_cmd_valid) |-> $past(frame_start));

    assert_read_opens_on_frame_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_busy) |-> $past(frame_start));

    assert_err_ones_R9: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_data == 16'hFFFF && !rd_timeout);

    assert_timeout_ones_R10: assert property (@(posedge clk) disable iff (rst)
        rd_timeout |-> rd_data == 16'hFFFF);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);
endmodule

bind ac_link_cmd_engine ac_link_cmd_checker u_chk (.*);

// File: tb/ac_link_cmd_engine_bench.sv
module ac_link_cmd_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RST_C = 8;
    localparam int WAKE_C = 40;
    localparam int TOTAL = RST_C + WAKE_C;
    localparam int FRAME = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_data_we = 0, host_cmd_we = 0, host_cmd_read = 0;
    logic [15:0] host_data = 0;
    logic [6:0] host_cmd_addr = 0;
    logic host_rx1_ack = 0, host_rx2_ack = 0;
    logic en_tx_cmd = 1, en_tx_data = 1, en_rx_cmd = 1, en_rx_data = 1;
    logic frame_start = 0;
    logic [19:0] rx_cmd_slot = 0, rx_data_slot = 0;
    logic rx_cmd_tag = 0, rx_data_tag = 0;
    logic [19:0] tx_cmd_slot, tx_data_slot, rx_cmd_word, rx_data_word;
    logic tx_cmd_tag, tx_data_tag, cmd_busy, data_busy, rx_cmd_valid, rx_data_valid;
    logic rd_busy, rd_done, rd_err, rd_timeout, codec_rst_n, link_ready;
    logic [15:0] rd_data;

    ac_link_cmd_engine #(.RESET_CYCLES(RST_C), .WAKE_CYCLES(WAKE_C), .TIMEOUT_FRAMES(4)) u_ac_link_cmd_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, fcnt = 0;
    int seen1 = 0, seen2 = 0, done_cnt = 0;
    logic [19:0] last1 = 0, last2 = 0;
    bit finished = 0;
    logic nx_dwe = 0, nx_cwe = 0, nx_rd = 0, nx_a1 = 0, nx_a2 = 0;
    logic [15:0] nx_data = 0;
    logic [6:0] nx_addr = 0;

    // behavioural reference state
    int m_cyc, m_cnt;
    logic [19:0] m_p1, m_p2, m_tx1, m_tx2, m_r1, m_r2;
    logic m_b1, m_b2, m_tg1, m_tg2, m_v1, m_v2, m_wait, m_done, m_err, m_to;
    logic [6:0] m_addr;
    logic [15:0] m_data;

    always @(posedge clk) begin
        bit rdy, s1, s2, st;
        if (rst) begin
            m_cyc = 0; m_cnt = 0; m_p1 = 0; m_p2 = 0; m_tx1 = 0; m_tx2 = 0;
            m_r1 = 0; m_r2 = 0; m_b1 = 0; m_b2 = 0; m_tg1 = 0; m_tg2 = 0;
            m_v1 = 0; m_v2 = 0; m_wait = 0; m_done = 0; m_err = 0; m_to = 0;
            m_addr = 0; m_data = 0;
        end else begin
            rdy = (m_cyc >= TOTAL);
            s1 = frame_start && rdy && m_b1 && en_tx_cmd;
            s2 = s1 && m_b2 && en_tx_data;
            st = rx_cmd_tag && rx_data_tag && en_rx_cmd && en_rx_data;
            m_done = 0;
            if (s1 && m_p1[19]) begin
                m_wait = 1; m_cnt = 0; m_addr = m_p1[18:12];
            end else if (m_wait && frame_start && rdy) begin
                if (st) begin
                    m_wait = 0; m_done = 1; m_to = 0;
                    if (rx_cmd_slot[18:12] == m_addr) begin m_data = rx_data_slot[19:4]; m_err = 0; end
                    else begin m_data = 16'hFFFF; m_err = 1; end
                end else begin
                    m_cnt++;
                    if (m_cnt == 4) begin m_wait = 0; m_done = 1; m_data = 16'hFFFF; m_err = 0; m_to = 1; end
                end
            end
            if (frame_start) begin
                m_tx1 = s1 ? m_p1 : 20'h0; m_tg1 = s1;
                m_tx2 = s2 ? m_p2 : 20'h0; m_tg2 = s2;
            end
            if (host_cmd_we) begin m_p1 = {host_cmd_read, host_cmd_addr, 12'h000}; m_b1 = 1; end
            else if (s1) m_b1 = 0;
            if (host_data_we) begin m_p2 = {host_data, 4'h0}; m_b2 = 1; end
            else if (s2) m_b2 = 0;
            if (frame_start && rdy && rx_cmd_tag && en_rx_cmd) begin m_r1 = rx_cmd_slot; m_v1 = 1; end
            else if (host_rx1_ack) m_v1 = 0;
            if (frame_start && rdy && rx_data_tag && en_rx_data) begin m_r2 = rx_data_slot; m_v2 = 1; end
            else if (host_rx2_ack) m_v2 = 0;
            if (m_cyc < TOTAL) m_cyc++;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1", "tx_cmd_slot", 32'(tx_cmd_slot), 32'(m_tx1));
        chk("R2", "tx_data_slot", 32'(tx_data_slot), 32'(m_tx2));
        chk("R6", "tags", {30'h0, tx_cmd_tag, tx_data_tag}, {30'h0, m_tg1, m_tg2});
        chk("R4", "busy", {30'h0, cmd_busy, data_busy}, {30'h0, m_b1, m_b2});
        chk("R7", "rx words", 32'(rx_cmd_word ^ (rx_data_word << 1)), 32'(m_r1 ^ (m_r2 << 1)));
        chk("R7", "rx valid", {30'h0, rx_cmd_valid, rx_data_valid}, {30'h0, m_v1, m_v2});
        chk("R8", "rd_busy/data", {15'h0, rd_busy, rd_data}, {15'h0, m_wait, m_data});
        chk("R9", "rd_err", 32'(rd_err), 32'(m_err));
        chk("R10", "rd_timeout", 32'(rd_timeout), 32'(m_to));
        chk("R12", "rd_done", 32'(rd_done), 32'(m_done));
        chk("R11", "rst/ready", {30'h0, codec_rst_n, link_ready},
            {30'h0, 1'(m_cyc >= RST_C), 1'(m_cyc >= TOTAL)});
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        if (frame_start && tx_cmd_tag) begin seen1++; last1 = tx_cmd_slot; end
        if (frame_start && tx_data_tag) begin seen2++; last2 = tx_data_slot; end
        if (rd_done) done_cnt++;
        if (rst) begin
            frame_start = 0;
        end else begin
            frame_start = (fcnt == 0);
            fcnt = (fcnt == FRAME - 1) ? 0 : fcnt + 1;
        end
        host_data_we = 0; host_cmd_we = 0; host_rx1_ack = 0; host_rx2_ack = 0;
        if (!frame_start) begin
            host_data_we = nx_dwe; host_data = nx_data;
            host_cmd_we = nx_cwe; host_cmd_read = nx_rd; host_cmd_addr = nx_addr;
            host_rx1_ack = nx_a1; host_rx2_ack = nx_a2;
            nx_dwe = 0; nx_cwe = 0; nx_a1 = 0; nx_a2 = 0;
        end
    endtask

    task automatic flush();
        tick();
        while (nx_dwe || nx_cwe || nx_a1 || nx_a2) tick();
        tick();
    endtask

    task automatic wr_data(input logic [15:0] d);
        nx_dwe = 1; nx_data = d; flush();
    endtask

    task automatic wr_cmd(input logic rd, input logic [6:0] a);
        nx_cwe = 1; nx_rd = rd; nx_addr = a; flush();
    endtask

    task automatic wait_frames(input int n);
        int c = 0;
        while (c < n) begin tick(); if (frame_start) c++; end
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R11", "codec_rst_n in reset", 32'(codec_rst_n), 0);
        chk("R11", "link_ready in reset", 32'(link_ready), 0);
        chk("R4", "busy in reset", {31'h0, cmd_busy}, 0);
        rst = 0;
        // R4 and R11: write issued before the link is ready stays pending
        wr_data(16'h801E);
        wr_cmd(1'b0, 7'h26);
        chk("R4", "both busy before ready", {30'h0, cmd_busy, data_busy}, 3);
        while (!link_ready) tick();
        chk("R11", "nothing sent before ready", seen1, 0);
        wait_frames(2);
        chk("R1", "write cmd word", 32'(last1), 32'h26000);
        chk("R2", "write data word", 32'(last2), 32'h801E0);
        chk("R4", "busy cleared after send", {30'h0, cmd_busy, data_busy}, 0);
        // R3: data alone does not go out
        wr_data(16'h1234);
        wait_frames(3);
        chk("R3", "data alone not sent", seen2, 1);
        chk("R3", "data still pending", 32'(data_busy), 1);
        wr_cmd(1'b0, 7'h02);
        wait_frames(2);
        chk("R3", "cmd sent", seen1, 2);
        chk("R3", "data sent with cmd", seen2, 2);
        chk("R2", "held data word", 32'(last2), 32'h12340);
        // R5: transmit enables
        en_tx_cmd = 0;
        wr_cmd(1'b0, 7'h04);
        wait_frames(3);
        chk("R5", "cmd held while disabled", seen1, 2);
        chk("R5", "cmd busy while disabled", 32'(cmd_busy), 1);
        en_tx_cmd = 1;
        wait_frames(2);
        chk("R5", "cmd sent after enable", 32'(last1), 32'h04000);
        en_tx_data = 0;
        wr_data(16'hABCD);
        wr_cmd(1'b0, 7'h06);
        wait_frames(2);
        chk("R5", "cmd left without data", seen1, 4);
        chk("R5", "data held", {31'h0, data_busy}, 1);
        en_tx_data = 1;
        wr_cmd(1'b0, 7'h08);
        wait_frames(2);
        chk("R5", "stale data carried", 32'(last2), 32'hABCD0);
        chk("R6", "data frames counted", seen2, 3);
        // R7: receive capture
        rx_cmd_slot = 20'hA5A5A; rx_cmd_tag = 1;
        wait_frames(1);
        rx_cmd_tag = 0;
        chk("R7", "captured valid", 32'(rx_cmd_valid), 1);
        chk("R7", "captured word", 32'(rx_cmd_word), 32'hA5A5A);
        nx_a1 = 1; flush();
        chk("R7", "ack clears valid", 32'(rx_cmd_valid), 0);
        en_rx_cmd = 0; rx_cmd_slot = 20'h11111; rx_cmd_tag = 1;
        wait_frames(2);
        chk("R7", "disabled keeps valid low", 32'(rx_cmd_valid), 0);
        chk("R7", "disabled keeps word", 32'(rx_cmd_word), 32'hA5A5A);
        en_rx_cmd = 1; rx_cmd_tag = 0;
        // R8: matching read
        rx_cmd_slot = 20'h7C000; rx_data_slot = 20'h59530; rx_cmd_tag = 1; rx_data_tag = 1;
        wr_cmd(1'b1, 7'h7C);
        wait_frames(3);
        chk("R8", "read data", 32'(rd_data), 32'h5953);
        chk("R8", "read flags", {30'h0, rd_err, rd_timeout}, 0);
        chk("R12", "one done pulse", done_cnt, 1);
        // R9: mismatch
        wr_cmd(1'b1, 7'h02);
        wait_frames(3);
        chk("R9", "mismatch data", 32'(rd_data), 32'hFFFF);
        chk("R9", "mismatch flag", 32'(rd_err), 1);
        chk("R12", "second done pulse", done_cnt, 2);
        // R10: timeout
        rx_cmd_tag = 0; rx_data_tag = 0;
        wr_cmd(1'b1, 7'h10);
        wait_frames(4);
        chk("R10", "still waiting after 3 silent frames", 32'(rd_busy), 1);
        chk("R10", "no done yet", done_cnt, 2);
        wait_frames(2);
        chk("R10", "timeout flag", 32'(rd_timeout), 1);
        chk("R10", "timeout data", 32'(rd_data), 32'hFFFF);
        chk("R12", "third done pulse", done_cnt, 3);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule